// File: doc/BRIEF.md
# Power-aware scan segment controller

This block sits in a test data register at the point where the chain enters a switchable power domain. It adds two scan cells on the always-on side, ahead of the domain. The power cell captures whether the domain is functionally on, and its update stage drives an override that can force the domain on for test. The mux control cell decides whether the domain's own scan segment is spliced into the chain or bypassed by a short path. The mux adds no bits to the chain.

During capture the control cell reloads its own update value. Test software can therefore read back the select it last applied. A typical session runs in four steps. Software sets the override and waits. It then reads the power bit until it shows the domain on. Only after that does it set the control bit, so the next scan sees the longer chain. Reset always returns to a collapsed chain with the domain in normal mode.

Top module: `pwr_seg_ctl`

## Requirements
- R1: On reset (`trst_n` low), `pwr_force` and `seg_sel` go to 0, and the chain from `si` to `so` is 2 bits long.
- R2: On a capture strobe, the power cell loads `pwr_sense`, where 1 means the domain is on and 0 means it is off. This bit is the last bit shifted out of a scan.
- R3: On an update strobe, `pwr_force` takes the power cell's shifted value. 1 forces the domain on and 0 leaves it in normal mode.
- R4: On a capture strobe, the control cell loads the current `seg_sel` and not any external input. This bit is the second-to-last bit shifted out.
- R5: With `seg_sel` at 1, the chain is `si`, then the power cell, then the control cell (driving `seg_si`), then the segment, with `so` taken from `seg_so`. Its length is 2+SEG_LEN. With `seg_sel` at 0, `so` comes straight from the control cell and the length is 2.
- R6: `seg_sel` and `pwr_force` change only on an update strobe or a reset. Shifting does not change the select or the chain length.
- R7: `seg_mode` equals `mode_in` while `seg_sel` is 1, and is 0 otherwise.
- R8: In a scan of length L, input bit L-1 (the last shifted in) lands in the power cell and bit L-2 lands in the control cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| si | input | 1 | Serial in from the TDI side |
| so | output | 1 | Serial out toward TDO |
| seg_si | output | 1 | Serial in to the switchable segment |
| seg_so | input | 1 | Serial out of the switchable segment |
| pwr_sense | input | 1 | Domain is functionally on |
| pwr_force | output | 1 | Override that forces domain power on |
| seg_sel | output | 1 | Segment included in chain |
| mode_in | input | 1 | Test mode for the segment's cells |
| seg_mode | output | 1 | Mode gated by the segment select |

## Verification
The bench measures the chain length by flushing it and timing a single marker bit. It does this collapsed, expanded, after a shift-only pass that loads a 0 into the control cell, and after a mid-run reset. A design that switched the select during shift, or failed to collapse on reset, would report the wrong length. Readback checks tie the last two bits shifted out to the sensed power state and to the applied select. A design that captured the wrong source for the control cell, or swapped the cell order, would miscompare there. Random scans also compare the override, the select and the gated mode against a bench model.

// File: rtl/pwr_seg_ctl.sv
module pwr_seg_ctl (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic si,
  output logic so,
  output logic seg_si,
  input  logic seg_so,
  input  logic pwr_sense,
  output logic pwr_force,
  output logic seg_sel,
  input  logic mode_in,
  output logic seg_mode
);

  logic pwr_sh, ctl_sh, pwr_up, ctl_up;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      pwr_sh <= 1'b0;
      ctl_sh <= 1'b0;
    end else if (cap_en) begin
      pwr_sh <= pwr_sense;
      ctl_sh <= ctl_up;
    end else if (shift_en) begin
      pwr_sh <= si;
      ctl_sh <= pwr_sh;
    end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      pwr_up <= 1'b0;
      ctl_up <= 1'b0;
    end else if (upd_en) begin
      pwr_up <= pwr_sh;
      ctl_up <= ctl_sh;
    end

  assign pwr_force = pwr_up;
  assign seg_sel   = ctl_up;
  assign seg_si    = ctl_sh;
  assign so        = ctl_up ? seg_so : ctl_sh;
  assign seg_mode  = mode_in & ctl_up;

  a_r1_reset_state: assert property (@(posedge tck)
    !trst_n |-> (!pwr_force && !seg_sel));

  a_r2_sense_captured: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (pwr_sh == $past(pwr_sense)));

  a_r4_self_monitor: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (ctl_sh == $past(seg_sel)));

  a_r3_override_update: assert property (@(posedge tck) disable iff (!trst_n)
    upd_en |=> (pwr_force == $past(pwr_sh) && seg_sel == $past(ctl_sh)));

  a_r6_select_held: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> ($stable(seg_sel) && $stable(pwr_force)));

  a_r5_short_path: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !cap_en && !upd_en && !seg_sel) |=> (so == $past(pwr_sh)));

endmodule

// File: tb/sim_pwr_seg_ctl.sv
`timescale 1ns/1ps
module sim_pwr_seg_ctl;
  localparam int SEG_LEN = 5;

  logic tck = 1'b0;
  logic trst_n, cap_en, shift_en, upd_en, si, pwr_sense, mode_in;
  logic so, seg_si, pwr_force, seg_sel, seg_mode;
  logic [SEG_LEN-1:0] seg;
  logic seg_so;
  int nchk = 0, nfail = 0;

  always #2.5 tck = ~tck;

  always @(posedge tck) if (shift_en) seg <= {seg[SEG_LEN-2:0], seg_si};
  assign seg_so = seg[SEG_LEN-1];

  pwr_seg_ctl u0 (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .si(si), .so(so), .seg_si(seg_si), .seg_so(seg_so), .pwr_sense(pwr_sense),
    .pwr_force(pwr_force), .seg_sel(seg_sel), .mode_in(mode_in), .seg_mode(seg_mode));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dr_scan(input int len, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    @(negedge tck); cap_en = 1'b1; @(posedge tck);
    for (int i = 0; i < len; i++) begin
      @(negedge tck); cap_en = 1'b0; shift_en = 1'b1; si = din[i]; dout[i] = so;
      @(posedge tck);
    end
    @(negedge tck); shift_en = 1'b0; upd_en = 1'b1; @(posedge tck);
    @(negedge tck); upd_en = 1'b0;
  endtask

  task automatic measure(output int n);
    int cnt;
    logic found;
    n = -1; found = 1'b0;
    @(negedge tck); shift_en = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge tck); si = 1'b0; @(posedge tck); end
    @(negedge tck); si = 1'b1; @(posedge tck);
    cnt = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge tck);
      if (so && !found) begin n = cnt; found = 1'b1; end
      si = 1'b0;
      @(posedge tck);
      cnt++;
    end
    @(negedge tck); shift_en = 1'b0;
  endtask

  function automatic int exp_len(input logic sel);
    return sel ? 2 + SEG_LEN : 2;
  endfunction

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] din, dout;
    logic m_sel, m_force, p, c, old_sel;
    int len, n;
    int unsigned seed;
    seed = $urandom(32'd1357);
    trst_n = 1'b0; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
    si = 1'b0; pwr_sense = 1'b0; mode_in = 1'b1; seg = '0;
    repeat (3) @(posedge tck);
    @(negedge tck);
    check("R1 force at reset", pwr_force, 0);
    check("R1 select at reset", seg_sel, 0);
    check("R7 mode gated at reset", seg_mode, 0);
    trst_n = 1'b1;
    measure(n);
    check("R1 collapsed length", n, 2);

    pwr_sense = 1'b1;
    dr_scan(2, 64'h0, dout);
    check("R2 sense on captured", dout[1], 1);
    check("R4 select 0 read back", dout[0], 0);
    pwr_sense = 1'b0;
    dr_scan(2, 64'h0, dout);
    check("R2 sense off captured", dout[1], 0);

    dr_scan(2, 64'h2, dout);
    check("R3 override set", pwr_force, 1);
    check("R8 control bit from position 0", seg_sel, 0);
    pwr_sense = 1'b1;
    repeat (10) @(posedge tck);
    dr_scan(2, 64'h2, dout);
    check("R2 domain read on", dout[1], 1);
    dr_scan(2, 64'h3, dout);
    check("R5 select applied", seg_sel, 1);
    check("R7 mode passes", seg_mode, 1);
    measure(n);
    check("R5 expanded length", n, 2 + SEG_LEN);
    check("R6 select held over shift", seg_sel, 1);
    measure(n);
    check("R6 length steady after zeros shifted", n, 2 + SEG_LEN);

    din = '0; din[SEG_LEN] = 1'b1; din[SEG_LEN+1] = 1'b1;
    dr_scan(2 + SEG_LEN, din, dout);
    check("R4 select 1 read back", dout[SEG_LEN], 1);
    check("R2 sense in expanded chain", dout[SEG_LEN+1], 1);

    m_sel = 1'b1; m_force = 1'b1;
    for (int k = 0; k < 40; k++) begin
      pwr_sense = 1'($urandom);
      mode_in = 1'($urandom);
      p = 1'($urandom); c = 1'($urandom);
      len = exp_len(m_sel);
      din = {$urandom, $urandom};
      din[len-2] = c; din[len-1] = p;
      old_sel = m_sel;
      dr_scan(len, din, dout);
      check("R4 random select read back", dout[len-2], old_sel);
      check("R2 random sense", dout[len-1], pwr_sense);
      m_sel = c; m_force = p;
      check("R3 random override", pwr_force, m_force);
      check("R8 random select", seg_sel, m_sel);
      check("R7 random gated mode", seg_mode, mode_in & m_sel);
    end

    if (!m_sel) dr_scan(2, 64'h3, dout);
    @(negedge tck); trst_n = 1'b0;
    @(negedge tck);
    check("R1 select cleared by reset", seg_sel, 0);
    check("R1 override cleared by reset", pwr_force, 0);
    trst_n = 1'b1;
    measure(n);
    check("R1 length after reset", n, 2);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule